// File: doc/BRIEF.md
# Fault Alert Latch and Responder

This block gathers the fault sources of a two-channel bus switch and drives a single active-low alert line toward the host. There are three kinds of source. Each downstream channel has its own active-low alert input. The connection logic sends a one-cycle pulse when a connect command is refused. The stuck-bus timer sends a one-cycle pulse when it expires. The faults fall into two classes, and each class has its own latch. The first class, the channel/connection class, records refused connections and alerts from channels that are not connected. The second class, the timeout class, records stuck-bus expiries. An alert from a channel that is connected is not latched. It passes straight through to the alert output.

The host finds the source of a fault in one of two ways. It can serve the alert response address, or it can address the device directly. The protocol engine reports each of these as a one-cycle pulse. While any class is asserting, the block raises a request asking the protocol engine to answer the alert response address. After a class is released, it does not assert again until a write to the first status register clears it and the fault occurs again. The same latches feed the status bits for that register: the synchronized channel alert levels, a refused-connection flag and a latched-timeout flag. While enable is low, every latch is held clear, but the channel alert inputs still drive the alert output.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After reset, `alert_n`=1, `ara_respond`=0, `stat_conn_fail`=0, `stat_timeout`=0 and `stat_ch_alert`=2'b11. Each channel alert input passes through two flops. `stat_ch_alert[i]` shows the level of `ch_alert_n[i]` without inversion, two clock edges after the input changes.
- R2: A low alert on a channel with `ch_connected[i]`=0 sets the channel/connection class. `alert_n` goes low after the third edge following the input change and stays low after the input returns high. `ara_respond` is 1 while the class asserts.
- R3: A low alert on a channel with `ch_connected[i]`=1 drives `alert_n` low two edges after the input falls. It releases `alert_n` two edges after the input rises. It latches nothing, so `ara_respond` stays 0.
- R4: A `conn_fail` pulse sets the channel/connection class and `stat_conn_fail`. `alert_n` is low after that edge.
- R5: A `stuck_timeout` pulse sets the timeout class and `stat_timeout`. `alert_n` is low after that edge.
- R6: An `ara_served` pulse releases one asserting class, choosing the timeout class before the channel/connection class. If both classes assert, `alert_n` stays low after one pulse and goes high after a second pulse.
- R7: An `addressed` pulse releases every asserting class. The status flags stay set.
- R8: A released class ignores further events of its own class until it is cleared. An event of the other class still drives `alert_n` low.
- R9: A `reg0_write` pulse clears both classes and both flags. A set event in the same cycle wins. An unconnected channel alert that is still low sets its class again at once.
- R10: While `enable`=0, the latches and flags are held clear and `conn_fail` and `stuck_timeout` have no effect. `alert_n` is low exactly when a synchronized channel alert is low, whether or not that channel is connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | High enables latching; low holds all latches clear |
| ch_alert_n | input | NUM_CH (2) | Active-low per-channel alert inputs, asynchronous |
| ch_connected | input | NUM_CH (2) | Per-channel connected-to-upstream flags |
| conn_fail | input | 1 | One-cycle pulse: a connect command was refused |
| stuck_timeout | input | 1 | One-cycle pulse: stuck-bus timer expired |
| reg0_write | input | 1 | One-cycle pulse: first status register was written (clear) |
| addressed | input | 1 | One-cycle pulse: device was addressed |
| ara_served | input | 1 | One-cycle pulse: alert response address was answered |
| alert_n | output | 1 | Active-low alert to host (0 = pull low) |
| ara_respond | output | 1 | Request to answer the alert response address |
| stat_ch_alert | output | NUM_CH (2) | Synchronized channel alert levels, non-inverted |
| stat_conn_fail | output | 1 | Refused connection seen since last clear |
| stat_timeout | output | 1 | Timeout latched since last clear |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an alert-response service and both fault classes pending at once. The bench pulses `conn_fail` and `stuck_timeout` in the same cycle and then serves the response address twice. It expects `alert_n` to stay low after the first service and to go high only after the second. The second pair is a register clear and a new fault. The bench pulses `reg0_write` in the same cycle as `stuck_timeout`. It also issues a clear while an unconnected channel alert is still held low. In both cases it expects the class to be latched again in that cycle rather than lost.

// File: rtl/fault_alert_pkg.sv
// Shared types for the fault alert block.
package fault_alert_pkg;
    // State of one fault class latch
    typedef enum logic [1:0] {
        CLS_IDLE     = 2'b00,
        CLS_ACTIVE   = 2'b01,
        CLS_RELEASED = 2'b10
    } cls_state_t;
endpackage

// File: rtl/fault_sync.sv
// Multi-stage synchronizer for a vector of asynchronous level inputs.
// Assumes inputs are quasi-static levels. Each flop resets to RESET_VAL.
module fault_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift one stage toward the output
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[s] <= {WIDTH{RESET_VAL}};
            else if (s == 0)
                stage_q[s] <= async_in;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/fault_class_latch.sv
// One fault class: idle -> active on a set event, active -> released on a
// release request, any state -> idle on clear (a set in the same cycle wins).
// A released class ignores set events until cleared. hold_idle forces idle.
module fault_class_latch
    import fault_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_idle,
    input  logic clear,
    input  logic set_evt,
    input  logic release_req,
    output logic active,
    output logic latched
);
    cls_state_t state_q, state_d;

    // Next-state selection for the class
    always_comb begin
        state_d = state_q;
        if (hold_idle)
            state_d = CLS_IDLE;
        else if (clear)
            state_d = set_evt ? CLS_ACTIVE : CLS_IDLE;
        else if (state_q == CLS_ACTIVE && release_req)
            state_d = CLS_RELEASED;
        else if (state_q == CLS_IDLE && set_evt)
            state_d = CLS_ACTIVE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CLS_IDLE;
        else        state_q <= state_d;
    end

    assign active  = (state_q == CLS_ACTIVE);
    assign latched = (state_q != CLS_IDLE);

    // R8
    released_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CLS_RELEASED && !clear) |=> !active);
    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !set_evt) |=> !latched);
    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && release_req && !clear && !hold_idle) |=> (latched && !active));
endmodule

// File: rtl/fault_alert_ctrl.sv
// Fault alert collector for a two-channel bus switch. Synchronizes the
// channel alert inputs, feeds the channel/connection and timeout classes,
// passes connected-channel alerts straight through, and requests an
// alert-response answer while a class asserts. All pulse inputs are one
// cycle wide and synchronous to clk.
module fault_alert_ctrl #(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [NUM_CH-1:0] ch_alert_n,
    input  logic [NUM_CH-1:0] ch_connected,
    input  logic              conn_fail,
    input  logic              stuck_timeout,
    input  logic              reg0_write,
    input  logic              addressed,
    input  logic              ara_served,
    output logic              alert_n,
    output logic              ara_respond,
    output logic [NUM_CH-1:0] stat_ch_alert,
    output logic              stat_conn_fail,
    output logic              stat_timeout
);
    logic [NUM_CH-1:0] ch_sync_n;
    logic [NUM_CH-1:0] unconn_fault;
    logic [NUM_CH-1:0] conn_pass;
    logic grp_active, grp_latched, tmo_active, tmo_latched;
    logic grp_set, grp_rel, tmo_rel;
    logic fail_flag_q;

    fault_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ch_alert_n),
        .sync_out (ch_sync_n)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Split each synchronized alert into latched and transparent paths
        always_comb begin
            unconn_fault[c] = !ch_sync_n[c] && !ch_connected[c];
            conn_pass[c]    = !ch_sync_n[c] &&  ch_connected[c];
        end
    end

    // Set and release requests; the timeout class is released first
    always_comb begin
        grp_set = conn_fail || (|unconn_fault);
        tmo_rel = addressed || (ara_served && tmo_active);
        grp_rel = addressed || (ara_served && !tmo_active);
    end

    fault_class_latch u_grp (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_idle   (!enable),
        .clear       (reg0_write),
        .set_evt     (grp_set),
        .release_req (grp_rel),
        .active      (grp_active),
        .latched     (grp_latched)
    );

    fault_class_latch u_tmo (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_idle   (!enable),
        .clear       (reg0_write),
        .set_evt     (stuck_timeout),
        .release_req (tmo_rel),
        .active      (tmo_active),
        .latched     (tmo_latched)
    );

    // Refused-connection status flag, cleared with the latches
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) fail_flag_q <= 1'b0;
        else if (reg0_write)   fail_flag_q <= conn_fail;
        else if (conn_fail)    fail_flag_q <= 1'b1;
    end

    // Alert output: all channels when disabled, else classes plus pass-through
    always_comb begin
        if (!enable)
            alert_n = &ch_sync_n;
        else
            alert_n = !(grp_active || tmo_active || (|conn_pass));
    end

    assign ara_respond    = grp_active || tmo_active;
    assign stat_ch_alert  = ch_sync_n;
    assign stat_conn_fail = fail_flag_q;
    assign stat_timeout   = tmo_latched;

    // R6
    ara_one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_served && grp_active && tmo_active && enable && !reg0_write && !addressed)
        |=> (!alert_n && ara_respond));
    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ara_respond && !stat_timeout && !stat_conn_fail));
    // R5
    timeout_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_timeout && enable && !tmo_latched) |=> (stat_timeout && !alert_n));
endmodule

// File: tb/fault_alert_ctrl_test.sv
module fault_alert_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic [1:0] ch_alert_n = 2'b11;
    logic [1:0] ch_connected = 2'b00;
    logic conn_fail = 0, stuck_timeout = 0, reg0_write = 0, addressed = 0, ara_served = 0;
    logic alert_n, ara_respond, stat_conn_fail, stat_timeout;
    logic [1:0] stat_ch_alert;
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    fault_alert_ctrl uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ch_alert_n(ch_alert_n),
        .ch_connected(ch_connected), .conn_fail(conn_fail), .stuck_timeout(stuck_timeout),
        .reg0_write(reg0_write), .addressed(addressed), .ara_served(ara_served),
        .alert_n(alert_n), .ara_respond(ara_respond), .stat_ch_alert(stat_ch_alert),
        .stat_conn_fail(stat_conn_fail), .stat_timeout(stat_timeout)
    );

    task automatic check(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse selected inputs for one cycle, sampled back at the next negedge
    task automatic pulse(input bit cf, input bit st, input bit clr, input bit adr, input bit ara);
        conn_fail = cf; stuck_timeout = st; reg0_write = clr; addressed = adr; ara_served = ara;
        step(1);
        conn_fail = 0; stuck_timeout = 0; reg0_write = 0; addressed = 0; ara_served = 0;
    endtask

    task automatic t_reset();
        check(alert_n, 1, "R1 reset alert_n");
        check(ara_respond, 0, "R1 reset ara_respond");
        check(stat_conn_fail, 0, "R1 reset stat_conn_fail");
        check(stat_timeout, 0, "R1 reset stat_timeout");
        check(stat_ch_alert, 3, "R1 reset stat_ch_alert");
    endtask

    task automatic t_connected_pass();
        ch_connected = 2'b01;
        ch_alert_n = 2'b10;
        step(1);
        check(stat_ch_alert, 3, "R1 one edge still old level");
        check(alert_n, 1, "R3 not yet through sync");
        step(1);
        check(stat_ch_alert, 2, "R1 level after two edges");
        check(alert_n, 0, "R3 connected alert passes");
        check(ara_respond, 0, "R3 not latched");
        ch_alert_n = 2'b11;
        step(2);
        check(alert_n, 1, "R3 pass-through released");
        check(ara_respond, 0, "R3 no latch left");
        ch_connected = 2'b00;
    endtask

    task automatic t_unconnected();
        ch_alert_n = 2'b01;
        step(2);
        check(alert_n, 1, "R2 not before third edge");
        step(1);
        check(alert_n, 0, "R2 latched alert");
        check(ara_respond, 1, "R2 ara request");
        ch_alert_n = 2'b11;
        step(4);
        check(alert_n, 0, "R2 stays latched");
        pulse(0, 0, 0, 0, 1);
        check(alert_n, 1, "R6 ara releases");
        check(ara_respond, 0, "R6 request dropped");
        ch_alert_n = 2'b01;
        step(4);
        check(alert_n, 1, "R8 released ignores recurrence");
        pulse(0, 0, 1, 0, 0);
        check(alert_n, 0, "R9 persisting alert relatches on clear");
        ch_alert_n = 2'b11;
        step(3);
        pulse(0, 0, 1, 0, 0);
        check(alert_n, 1, "R9 clear after fault gone");
        check(ara_respond, 0, "R9 nothing pending");
    endtask

    task automatic t_conn_fail();
        pulse(1, 0, 0, 0, 0);
        check(alert_n, 0, "R4 conn_fail alert");
        check(stat_conn_fail, 1, "R4 flag set");
        check(ara_respond, 1, "R4 request");
        pulse(0, 0, 0, 1, 0);
        check(alert_n, 1, "R7 addressed releases");
        check(stat_conn_fail, 1, "R7 flag kept");
        pulse(1, 0, 0, 0, 0);
        check(alert_n, 1, "R8 same class ignored");
        pulse(0, 1, 0, 0, 0);
        check(alert_n, 0, "R8 other class asserts");
        check(stat_timeout, 1, "R5 timeout flag");
        pulse(0, 0, 0, 0, 1);
        check(alert_n, 1, "R6 timeout released");
        pulse(0, 0, 1, 0, 0);
        check(stat_conn_fail, 0, "R9 conn flag cleared");
        check(stat_timeout, 0, "R9 timeout flag cleared");
    endtask

    task automatic t_both();
        pulse(1, 1, 0, 0, 0);
        check(alert_n, 0, "R6 both pending");
        pulse(0, 0, 0, 0, 1);
        check(alert_n, 0, "R6 one class left after first ara");
        check(ara_respond, 1, "R6 still requesting");
        check(stat_timeout, 1, "R6 timeout latched but released");
        pulse(0, 0, 0, 0, 1);
        check(alert_n, 1, "R6 second ara releases");
        check(ara_respond, 0, "R6 request dropped");
        pulse(0, 0, 1, 0, 0);
    endtask

    task automatic t_clear_coincide();
        pulse(0, 1, 1, 0, 0);
        check(stat_timeout, 1, "R9 set wins over clear");
        check(alert_n, 0, "R9 set wins alert");
        pulse(0, 0, 1, 0, 0);
        check(stat_timeout, 0, "R9 plain clear");
        check(alert_n, 1, "R9 alert released by clear");
    endtask

    task automatic t_enable();
        pulse(1, 0, 0, 0, 0);
        check(alert_n, 0, "R10 pre-disable alert");
        enable = 0;
        step(1);
        check(alert_n, 1, "R10 disabled clears latch");
        check(stat_conn_fail, 0, "R10 flag cleared");
        check(ara_respond, 0, "R10 no request");
        pulse(1, 1, 0, 0, 0);
        check(alert_n, 1, "R10 pulses ignored");
        check(stat_timeout, 0, "R10 timeout ignored");
        ch_alert_n = 2'b10;
        step(2);
        check(alert_n, 0, "R10 channel alert still drives");
        ch_alert_n = 2'b11;
        step(2);
        check(alert_n, 1, "R10 channel alert gone");
        enable = 1;
        step(1);
        check(alert_n, 1, "R10 re-enable quiet");
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        t_reset();
        t_connected_pass();
        t_unconnected();
        t_conn_fail();
        t_both();
        t_clear_coincide();
        t_enable();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule